// File: doc/BRIEF.md
# Vector Compare-to-Mask Lane

This block is a single integer lane of a vector unit. It holds a small bank of vector registers and a mask register with one bit per element position. A compare instruction steps through the active elements of two vector registers, or of one vector register against a scalar. For each element it records in the mask whether a signed relation holds. Later add and subtract instructions then update only the destination elements whose mask bit is set. This gives element-wise conditional execution without branches.

An index-fill instruction writes 0, s, 2s, 3s and so on into a destination register. Software uses these values to build position lists for compress-style code. Every instruction processes elements 0 to VL-1 at one element per clock, where VL comes from the length input captured at start. An element that the mask turns off still takes its cycle, but no write happens for it. Operand registers are filled through a host element-write port and read back through a combinational element-read port. Both ports work only while the lane is idle.

Top module: `vcmp_mask_lane`

## Requirements
- R1: After reset, every mask bit is 1, and busy and done are 0.
- R2: A compare (op code 0) sets mask bit i to 1 when the signed relation between element i of src_a and element i of src_b holds, and clears it to 0 otherwise. The cond codes are 0 equal, 1 not equal, 2 greater, 3 less, 4 greater-or-equal, 5 less-or-equal, with src_a on the left.
- R3: With use_scalar set, the right-hand operand of a compare, add or subtract is the scalar input for every element, in place of src_b.
- R4: A compare leaves mask bits at positions VL and above unchanged.
- R5: Add (op code 1, a+b) and subtract (op code 2, a-b) write element i of dst modulo 2^W only where mask bit i is 1. All other elements of every register keep their value.
- R6: An instruction keeps busy high for exactly VL cycles, one element per cycle. Done is a single-cycle pulse in the cycle after the last element. With VL=0, done pulses in the cycle after start and no state changes.
- R7: Index fill (op code 3) writes i*scalar modulo 2^W into element i of dst for every i below VL, whatever the mask holds.
- R8: A length input above the maximum vector length (64) is treated as 64.
- R9: While busy is high, start and host writes have no effect.
- R10: Cond codes 6 and 7 clear every active mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction when idle |
| op | input | 2 | 0 compare, 1 add, 2 subtract, 3 index fill |
| cond | input | 3 | Compare relation code |
| use_scalar | input | 1 | Use the scalar as the right operand |
| dst | input | 2 | Destination register |
| src_a | input | 2 | Left operand register |
| src_b | input | 2 | Right operand register |
| scalar | input | 16 | Scalar operand or index step |
| vl | input | 7 | Vector length for this instruction |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| mask | output | 64 | Mask register contents |
| host_we | input | 1 | Host element write enable |
| host_reg | input | 2 | Host write register |
| host_idx | input | 6 | Host write element index |
| host_wdata | input | 16 | Host write data |
| peek_reg | input | 2 | Read-back register |
| peek_idx | input | 6 | Read-back element index |
| peek_data | output | 16 | Read-back element value |

## Verification
A wrong element counter or length latch shows at once in the length of the busy window and in where done falls. It also shows on the next compare, as mask bits written past VL or left stale below it. A mask bit that is wrong inside the lane stays hidden until a masked add or subtract runs. It then appears as exactly one destination element that was written or skipped when it should not have been. For that reason every compare sweep is followed by a masked arithmetic pass and a read-back of every register. A stale index accumulator shows as a wrong step in the first index fill that follows.

// File: rtl/vlane_pkg.sv
package vlane_pkg;
    typedef enum logic [1:0] {
        OP_CMP = 2'd0,
        OP_ADD = 2'd1,
        OP_SUB = 2'd2,
        OP_IDX = 2'd3
    } vop_e;

    typedef enum logic [2:0] {
        C_EQ  = 3'd0,
        C_NE  = 3'd1,
        C_GT  = 3'd2,
        C_LT  = 3'd3,
        C_GE  = 3'd4,
        C_LE  = 3'd5,
        C_RS6 = 3'd6,
        C_RS7 = 3'd7
    } vcond_e;
endpackage

// File: rtl/vlane_regfile.sv
module vlane_regfile #(
    parameter int W     = 16,
    parameter int NREG  = 4,
    parameter int MAXVL = 64,
    localparam int RW   = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int IW   = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [RW-1:0] w_reg,
    input  logic [IW-1:0] w_idx,
    input  logic [W-1:0]  w_data,
    input  logic [RW-1:0] a_reg,
    input  logic [IW-1:0] a_idx,
    output logic [W-1:0]  a_data,
    input  logic [RW-1:0] b_reg,
    input  logic [IW-1:0] b_idx,
    output logic [W-1:0]  b_data,
    input  logic [RW-1:0] c_reg,
    input  logic [IW-1:0] c_idx,
    output logic [W-1:0]  c_data
);
    logic [W-1:0] mem [NREG][MAXVL];

    always_ff @(posedge clk) begin
        if (we) mem[w_reg][w_idx] <= w_data;
    end

    assign a_data = mem[a_reg][a_idx];
    assign b_data = mem[b_reg][b_idx];
    assign c_data = mem[c_reg][c_idx];
endmodule

// File: rtl/vlane_alu.sv
module vlane_alu
    import vlane_pkg::*;
#(
    parameter int W = 16
) (
    input  vop_e         op,
    input  vcond_e       cond,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] acc,
    output logic [W-1:0] res,
    output logic         flag
);
    always_comb begin
        unique case (cond)
            C_EQ:    flag = (a == b);
            C_NE:    flag = (a != b);
            C_GT:    flag = ($signed(a) >  $signed(b));
            C_LT:    flag = ($signed(a) <  $signed(b));
            C_GE:    flag = ($signed(a) >= $signed(b));
            C_LE:    flag = ($signed(a) <= $signed(b));
            default: flag = 1'b0;
        endcase
    end

    always_comb begin
        unique case (op)
            OP_ADD:  res = a + b;
            OP_SUB:  res = a - b;
            OP_IDX:  res = acc;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/vcmp_mask_lane.sv
module vcmp_mask_lane
    import vlane_pkg::*;
#(
    parameter int W     = 16,
    parameter int NREG  = 4,
    parameter int MAXVL = 64,
    localparam int RW   = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int IW   = (MAXVL > 1) ? $clog2(MAXVL) : 1,
    localparam int VLW  = $clog2(MAXVL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       op,
    input  logic [2:0]       cond,
    input  logic             use_scalar,
    input  logic [RW-1:0]    dst,
    input  logic [RW-1:0]    src_a,
    input  logic [RW-1:0]    src_b,
    input  logic [W-1:0]     scalar,
    input  logic [VLW-1:0]   vl,
    output logic             busy,
    output logic             done,
    output logic [MAXVL-1:0] mask,
    input  logic             host_we,
    input  logic [RW-1:0]    host_reg,
    input  logic [IW-1:0]    host_idx,
    input  logic [W-1:0]     host_wdata,
    input  logic [RW-1:0]    peek_reg,
    input  logic [IW-1:0]    peek_idx,
    output logic [W-1:0]     peek_data
);
    typedef struct packed {
        logic             busy;
        logic             done;
        logic [IW-1:0]    idx;
        logic [VLW-1:0]   len;
        vop_e             op;
        vcond_e           cond;
        logic             use_s;
        logic [RW-1:0]    dst;
        logic [RW-1:0]    sa;
        logic [RW-1:0]    sb;
        logic [W-1:0]     scalar;
        logic [W-1:0]     acc;
        logic [MAXVL-1:0] mask;
    } lane_st_t;

    lane_st_t s_d, s_q;

    logic [W-1:0]   rd_a, rd_b, opnd_b, alu_res;
    logic           alu_flag;
    logic           lane_we;
    logic           rf_we;
    logic [RW-1:0]  rf_wreg;
    logic [IW-1:0]  rf_widx;
    logic [W-1:0]   rf_wdata;
    logic [VLW-1:0] len_in;

    vlane_regfile #(.W(W), .NREG(NREG), .MAXVL(MAXVL)) u_rf (
        .clk    (clk),
        .we     (rf_we),
        .w_reg  (rf_wreg),
        .w_idx  (rf_widx),
        .w_data (rf_wdata),
        .a_reg  (s_q.sa),
        .a_idx  (s_q.idx),
        .a_data (rd_a),
        .b_reg  (s_q.sb),
        .b_idx  (s_q.idx),
        .b_data (rd_b),
        .c_reg  (peek_reg),
        .c_idx  (peek_idx),
        .c_data (peek_data)
    );

    assign opnd_b = s_q.use_s ? s_q.scalar : rd_b;

    vlane_alu #(.W(W)) u_alu (
        .op   (s_q.op),
        .cond (s_q.cond),
        .a    (rd_a),
        .b    (opnd_b),
        .acc  (s_q.acc),
        .res  (alu_res),
        .flag (alu_flag)
    );

    assign len_in = (vl > VLW'(MAXVL)) ? VLW'(MAXVL) : vl;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        lane_we  = 1'b0;
        if (s_q.busy) begin
            unique case (s_q.op)
                OP_CMP:         s_d.mask[s_q.idx] = alu_flag;
                OP_ADD, OP_SUB: lane_we = s_q.mask[s_q.idx];
                OP_IDX:         lane_we = 1'b1;
                default:        lane_we = 1'b0;
            endcase
            s_d.acc = s_q.acc + s_q.scalar;
            if ((VLW'(s_q.idx) + VLW'(1)) == s_q.len) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end else begin
                s_d.idx = s_q.idx + IW'(1);
            end
        end else if (start) begin
            s_d.op     = vop_e'(op);
            s_d.cond   = vcond_e'(cond);
            s_d.use_s  = use_scalar;
            s_d.dst    = dst;
            s_d.sa     = src_a;
            s_d.sb     = src_b;
            s_d.scalar = scalar;
            s_d.len    = len_in;
            s_d.idx    = '0;
            s_d.acc    = '0;
            if (len_in == '0) s_d.done = 1'b1;
            else              s_d.busy = 1'b1;
        end
    end

    always_comb begin
        if (s_q.busy) begin
            rf_we    = lane_we;
            rf_wreg  = s_q.dst;
            rf_widx  = s_q.idx;
            rf_wdata = alu_res;
        end else begin
            rf_we    = host_we;
            rf_wreg  = host_reg;
            rf_widx  = host_idx;
            rf_wdata = host_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mask <= '1;
        end else begin
            s_q      <= s_d;
        end
    end

    assign busy = s_q.busy;
    assign done = s_q.done;
    assign mask = s_q.mask;
endmodule

// File: rtl/vlane_chk.sv
module vlane_chk #(
    parameter int MAXVL = 64,
    parameter int VLW   = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [VLW-1:0]   vl,
    input logic             busy,
    input logic             done,
    input logic [MAXVL-1:0] mask
);
    logic [VLW-1:0] len_lat, cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_lat <= '0;
            cnt     <= '0;
        end else if (start && !busy) begin
            len_lat <= (vl > VLW'(MAXVL)) ? VLW'(MAXVL) : vl;
            cnt     <= '0;
        end else if (busy) begin
            cnt <= cnt + VLW'(1);
        end
    end

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (mask == '1 && !busy && !done));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r6_end_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r6_cycle_count: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cnt == len_lat));

    a_r8_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt < len_lat && len_lat <= VLW'(MAXVL)));

    a_r9_mask_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(mask));
endmodule

bind vcmp_mask_lane vlane_chk #(.MAXVL(MAXVL), .VLW(VLW)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .vl    (vl),
    .busy  (busy),
    .done  (done),
    .mask  (mask)
);

// File: tb/vcmp_mask_lane_test.sv
module vcmp_mask_lane_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = '0;
    logic [2:0]  cond = '0;
    logic        use_scalar = 1'b0;
    logic [1:0]  dst = '0, src_a = '0, src_b = '0;
    logic [15:0] scalar = '0;
    logic [6:0]  vl = '0;
    logic        busy, done;
    logic [63:0] mask;
    logic        host_we = 1'b0;
    logic [1:0]  host_reg = '0;
    logic [5:0]  host_idx = '0;
    logic [15:0] host_wdata = '0;
    logic [1:0]  peek_reg = '0;
    logic [5:0]  peek_idx = '0;
    logic [15:0] peek_data;

    int checks = 0;
    int errors = 0;
    logic [15:0] mdl [4][64];
    logic [63:0] mm;

    always #10 clk = ~clk;

    vcmp_mask_lane uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .cond(cond),
        .use_scalar(use_scalar), .dst(dst), .src_a(src_a), .src_b(src_b),
        .scalar(scalar), .vl(vl), .busy(busy), .done(done), .mask(mask),
        .host_we(host_we), .host_reg(host_reg), .host_idx(host_idx),
        .host_wdata(host_wdata), .peek_reg(peek_reg), .peek_idx(peek_idx),
        .peek_data(peek_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit rel(input int c, input logic [15:0] a, input logic [15:0] b);
        case (c)
            0: return a == b;
            1: return a != b;
            2: return $signed(a) >  $signed(b);
            3: return $signed(a) <  $signed(b);
            4: return $signed(a) >= $signed(b);
            5: return $signed(a) <= $signed(b);
            default: return 1'b0;
        endcase
    endfunction

    task automatic host_fill(input int r, input int kind);
        for (int i = 0; i < 64; i++) begin
            logic [15:0] v;
            if (kind == 0) v = 16'((i * 3001) ^ 16'h8a5c);
            else if (i % 5 == 0) v = mdl[0][i];
            else v = 16'(i * 2749 + 16'h7000);
            @(negedge clk);
            host_we = 1'b1; host_reg = 2'(r); host_idx = 6'(i); host_wdata = v;
            mdl[r][i] = v;
        end
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic check_regs(input string tag);
        for (int r = 0; r < 4; r++) begin
            int bad = 0;
            logic [15:0] fa = '0, fe = '0;
            for (int i = 0; i < 64; i++) begin
                peek_reg = 2'(r); peek_idx = 6'(i);
                #1;
                if (peek_data !== mdl[r][i]) begin
                    if (bad == 0) begin fa = peek_data; fe = mdl[r][i]; end
                    bad++;
                end
            end
            chk(bad == 0, $sformatf("%s reg%0d", tag, r), 64'(fa), 64'(fe));
        end
    endtask

    task automatic run(input int op_i, input int cond_i, input bit us, input int d,
                       input int a, input int b, input logic [15:0] s,
                       input int vl_i, input bit poke, input string tag);
        int vle = (vl_i > 64) ? 64 : vl_i;
        int cyc = 0;
        bit pending = 1'b0;
        for (int i = 0; i < vle; i++) begin
            logic [15:0] rb = us ? s : mdl[b][i];
            case (op_i)
                0: mm[i] = rel(cond_i, mdl[a][i], rb);
                1: if (mm[i]) mdl[d][i] = mdl[a][i] + rb;
                2: if (mm[i]) mdl[d][i] = mdl[a][i] - rb;
                default: mdl[d][i] = 16'(i * int'(s));
            endcase
        end
        @(negedge clk);
        op = 2'(op_i); cond = 3'(cond_i); use_scalar = us; dst = 2'(d);
        src_a = 2'(a); src_b = 2'(b); scalar = s; vl = 7'(vl_i); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 300; k++) begin
            if (pending) begin start = 1'b0; host_we = 1'b0; pending = 1'b0; end
            if (done) break;
            if (busy) cyc++;
            if (poke && cyc == 2 && !pending && busy) begin
                // R9: intruding start and host write during a run
                op = 2'd3; dst = 2'd3; scalar = 16'd5; vl = 7'd64; start = 1'b1;
                host_we = 1'b1; host_reg = 2'd3; host_idx = 6'd0; host_wdata = 16'hdead;
                pending = 1'b1;
            end
            @(negedge clk);
        end
        chk(done === 1'b1, {tag, " R6 done seen"}, 64'(done), 64'd1);
        chk(cyc == vle, {tag, " R6 busy cycles"}, 64'(cyc), 64'(vle));
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, {tag, " R6 done one cycle"}, 64'({busy, done}), 64'd0);
        chk(mask === mm, {tag, " mask"}, mask, mm);
        check_regs(tag);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        mm = '1;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(mask === '1, "R1 mask ones", mask, '1);
        chk(busy === 1'b0 && done === 1'b0, "R1 idle", 64'({busy, done}), 64'd0);
        rst_n = 1'b1;
        for (int r = 2; r < 4; r++) for (int i = 0; i < 64; i++) mdl[r][i] = 16'(r * 1111 + i);
        host_fill(2, 0);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            host_we = 1'b1; host_reg = 2'd2; host_idx = 6'(i); host_wdata = 16'(2 * 1111 + i);
            mdl[2][i] = 16'(2 * 1111 + i);
            @(negedge clk);
            host_reg = 2'd3; host_wdata = 16'(3 * 1111 + i);
            mdl[3][i] = 16'(3 * 1111 + i);
        end
        @(negedge clk); host_we = 1'b0;
        host_fill(0, 0);
        host_fill(1, 1);
        // R5 with the default all-ones mask
        run(1, 0, 0, 2, 0, 1, 16'h0, 64, 0, "R5 add unmasked");
        // R2, R10: every relation code, vector-vector
        for (int c = 0; c < 8; c++) begin
            run(0, c, 0, 0, 0, 1, 16'h0, 64, 0, $sformatf("R2 R10 cmp cond%0d", c));
            run(1, 0, 0, 2, 0, 1, 16'h0, 64, 0, $sformatf("R5 add after cond%0d", c));
        end
        // R3, R4: vector-scalar compares with a short length
        for (int c = 0; c < 6; c++) begin
            run(0, 0, 0, 0, 0, 1, 16'h0, 64, 0, "R4 prep mask");
            run(0, c, 1, 0, 1, 0, 16'hff00, 40, 0, $sformatf("R3 R4 scalar cmp cond%0d", c));
            run(2, 0, 1, 3, 0, 0, 16'h0123, 50, 0, $sformatf("R5 R3 masked sub cond%0d", c));
        end
        // R7: index fill ignores the mask
        run(0, 6, 0, 0, 0, 1, 16'h0, 64, 0, "R10 clear mask");
        run(3, 0, 0, 2, 0, 0, 16'd7, 64, 0, "R7 index step7");
        run(3, 0, 0, 3, 0, 0, 16'h1234, 33, 0, "R7 index wrap");
        // R5: masked add with an all-zero mask writes nothing
        run(1, 0, 0, 2, 0, 1, 16'h0, 64, 0, "R5 add mask zero");
        // R6: zero length
        run(0, 0, 0, 0, 0, 0, 16'h0, 0, 0, "R6 zero length");
        // R8: length above the maximum is clamped
        run(0, 4, 0, 0, 2, 3, 16'h0, 100, 0, "R8 clamp cmp");
        run(3, 0, 0, 1, 0, 0, 16'hfffd, 127, 0, "R8 clamp index");
        // R9: start and host write ignored while busy
        run(1, 0, 0, 2, 0, 1, 16'h0, 64, 1, "R9 busy poke");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule